// File: doc/BRIEF.md
# Serial Hex Record RAM Loader

This block sits behind a UART receiver and turns a stream of received characters into RAM writes. Bytes arrive one at a time through a valid/data strobe, each with an error flag from the receiver. The block first expects a single command byte. A correct command is echoed. A wrong one is answered with an error code and the block stops.

After the command, the block scans for a record start mark and decodes text records of hexadecimal character pairs. Data records are written byte by byte into a RAM through a one-cycle write strobe. An end record closes the load. The block then sends a 16-bit sum of every byte it wrote and reports the address of the first data record as the place to continue execution.

Any receive error or malformed record drops the block into a halt state. No reply is sent on that path, and only reset leaves it.

Top module: `hexram_loader`

## Requirements
- R1: After reset, tx_valid, ram_we, done and halted are all 0.
- R2: A first received byte of 0x60 is answered with exactly one transmitted byte 0x60, after which the block looks for a record start mark.
- R3: A first received byte other than 0x60 is answered with the byte 0x63 transmitted three times, then halted goes to 1 with no further transmission.
- R4: While looking for a start mark, every received byte other than 0x3A (':') is discarded, including hex digits: it causes no write, no transmission and no halt.
- R5: After ':' a record is read as pairs of ASCII hex characters, high nibble first. Both 'A'-'F' and 'a'-'f' are accepted. The pairs are, in order: length, address high byte, address low byte, type, length data bytes, record checksum.
- R6: In a type 0x00 record, data byte i (from 0) is written with ram_we=1 for one cycle to the RAM address formed by the low AW bits of (record address + i). The write happens in the cycle after its second character is taken. Bytes already written stay written if the record later fails.
- R7: A character inside a record that is not a hex digit sends the block to halt without any transmission.
- R8: If the low byte of the sum of length, both address bytes, type, data and checksum is not zero, the block halts at the checksum pair without transmission.
- R9: Type 0x01 with length 0 is the end record. Any other type, or a type 0x01 record with non-zero length, halts the block at the type pair.
- R10: A received byte flagged with rx_err halts the block in the command, scan or record phase.
- R11: After a valid end record, the block transmits the modulo-65536 sum of all bytes written to RAM, upper byte first, then lower byte.
- R12: Once the lower sum byte is accepted, done goes to 1 and stays. jump_addr then holds the address of the first data record, or 0 if there was none.
- R13: Halt is sticky: once halted, received bytes cause no write and no transmission until reset.
- R14: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | The received byte had a framing or parity fault |
| tx_valid | output | 1 | A byte is offered for transmission |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes tx_data this cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | Load finished and sum sent |
| jump_addr | output | 16 | Address of the first data record |
| halted | output | 1 | Sticky error halt |

## Verification
The loader is driven with a clean load that mixes upper- and lower-case records and includes a record that wraps the RAM address. Garbage placed ahead of each start mark shows that scanning really discards bytes, since it contains hex digits that would otherwise corrupt fields. A load that holds only an end record separates the first-record jump latch from a default of zero and checks an empty sum. Separate loads each inject one fault: a wrong command, a non-hex character, a bad checksum, an unknown type, a non-empty end record and a receiver error. Each of these must halt quietly, and a full valid record sent afterwards must produce neither writes nor transmission.

// File: rtl/hl_pkg.sv
package hl_pkg;
   typedef enum logic [3:0] {
      S_CMD, S_ECHO, S_ERR, S_SEEK, S_FIELD, S_SUMH, S_SUML, S_DONE, S_HALT
   } ld_state_t;

   typedef enum logic [2:0] {
      F_LEN, F_AH, F_AL, F_TYP, F_DAT, F_CK
   } fld_t;

   localparam logic [7:0] CMD_LOAD  = 8'h60;
   localparam logic [7:0] CMD_BAD   = 8'h63;
   localparam logic [7:0] START_CH  = 8'h3A;
   localparam logic [7:0] TYP_DATA  = 8'h00;
   localparam logic [7:0] TYP_END   = 8'h01;
endpackage

// File: rtl/hl_ascii_dec.sv
module hl_ascii_dec #(
   parameter bit LOWER_OK = 1'b1
) (
   input  logic [7:0] ch,
   output logic [3:0] nib,
   output logic       ok
);
   logic is_dig, is_up;

   always_comb begin
      is_dig = (ch >= 8'h30) && (ch <= 8'h39);
      is_up  = (ch >= 8'h41) && (ch <= 8'h46);
      nib    = is_dig ? ch[3:0] : (ch[3:0] + 4'd9);
   end

   generate
      if (LOWER_OK) begin : g_lower
         logic is_lo;
         always_comb begin
            is_lo = (ch >= 8'h61) && (ch <= 8'h66);
            ok    = is_dig || is_up || is_lo;
         end
      end else begin : g_upper_only
         always_comb ok = is_dig || is_up;
      end
   endgenerate
endmodule

// File: rtl/hl_sum.sv
module hl_sum #(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_en,
   input  logic [7:0]    add_val,
   output logic [SW-1:0] sum
);
   initial assert (SW >= 8) else $error("hl_sum: SW must be at least 8");

   always_ff @(posedge clk) begin
      if (!rst_n)      sum <= '0;
      else if (add_en) sum <= sum + SW'(add_val);
   end

   p_sum_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !add_en |=> $stable(sum));
endmodule

// File: rtl/hexram_loader.sv
module hexram_loader #(
   parameter int AW         = 12,
   parameter int ERR_REPEAT = 3,
   parameter bit LOWER_OK   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_err,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   input  logic          tx_ready,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   output logic          done,
   output logic [15:0]   jump_addr,
   output logic          halted
);
   import hl_pkg::*;

   localparam int SUM_W = 16;
   localparam int ECW   = $clog2(ERR_REPEAT + 1);

   initial assert (AW >= 8 && AW <= 16) else $error("hexram_loader: AW out of 8..16");
   initial assert (ERR_REPEAT >= 1) else $error("hexram_loader: ERR_REPEAT must be >= 1");

   ld_state_t        st;
   fld_t             fld;
   logic             lo_ph;
   logic [3:0]       hi_nib;
   logic [7:0]       len, cnt, sum8;
   logic [15:0]      rec_addr;
   logic             is_end, first_seen;
   logic [ECW-1:0]   err_cnt;
   logic [3:0]       nib;
   logic             hex_ok;
   logic [7:0]       byte_now;
   logic             byte_done;
   logic [AW-1:0]    dat_addr;
   logic [SUM_W-1:0] sum16;

   hl_ascii_dec #(.LOWER_OK(LOWER_OK)) dec_i (
      .ch (rx_data), .nib (nib), .ok (hex_ok)
   );

   always_comb begin
      byte_now  = {hi_nib, nib};
      byte_done = (st == S_FIELD) && rx_valid && !rx_err && hex_ok && lo_ph;
      dat_addr  = rec_addr[AW-1:0] + AW'(cnt);
   end

   hl_sum #(.SW(SUM_W)) sum_i (
      .clk (clk), .rst_n (rst_n),
      .add_en (byte_done && (fld == F_DAT)),
      .add_val (byte_now),
      .sum (sum16)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_CMD;
         fld        <= F_LEN;
         lo_ph      <= 1'b0;
         hi_nib     <= '0;
         len        <= '0;
         cnt        <= '0;
         sum8       <= '0;
         rec_addr   <= '0;
         is_end     <= 1'b0;
         first_seen <= 1'b0;
         jump_addr  <= '0;
         err_cnt    <= '0;
         ram_we     <= 1'b0;
         ram_addr   <= '0;
         ram_wdata  <= '0;
      end else begin
         ram_we <= 1'b0;
         case (st)
            S_CMD: if (rx_valid) begin
               if (rx_err)                   st <= S_HALT;
               else if (rx_data == CMD_LOAD) st <= S_ECHO;
               else begin
                  st      <= S_ERR;
                  err_cnt <= '0;
               end
            end
            S_ECHO: if (tx_ready) st <= S_SEEK;
            S_ERR: if (tx_ready) begin
               if (err_cnt == ECW'(ERR_REPEAT - 1)) st <= S_HALT;
               else err_cnt <= err_cnt + 1'b1;
            end
            S_SEEK: if (rx_valid) begin
               if (rx_err) st <= S_HALT;
               else if (rx_data == START_CH) begin
                  st    <= S_FIELD;
                  fld   <= F_LEN;
                  lo_ph <= 1'b0;
                  sum8  <= '0;
               end
            end
            S_FIELD: if (rx_valid) begin
               if (rx_err || !hex_ok) st <= S_HALT;
               else if (!lo_ph) begin
                  hi_nib <= nib;
                  lo_ph  <= 1'b1;
               end else begin
                  lo_ph <= 1'b0;
                  sum8  <= sum8 + byte_now;
                  case (fld)
                     F_LEN: begin len <= byte_now; fld <= F_AH; end
                     F_AH:  begin rec_addr[15:8] <= byte_now; fld <= F_AL; end
                     F_AL:  begin rec_addr[7:0]  <= byte_now; fld <= F_TYP; end
                     F_TYP: begin
                        cnt <= '0;
                        if (byte_now == TYP_DATA) begin
                           is_end <= 1'b0;
                           if (!first_seen) begin
                              first_seen <= 1'b1;
                              jump_addr  <= rec_addr;
                           end
                           fld <= (len == 8'd0) ? F_CK : F_DAT;
                        end else if (byte_now == TYP_END && len == 8'd0) begin
                           is_end <= 1'b1;
                           fld    <= F_CK;
                        end else st <= S_HALT;
                     end
                     F_DAT: begin
                        ram_we    <= 1'b1;
                        ram_addr  <= dat_addr;
                        ram_wdata <= byte_now;
                        cnt       <= cnt + 8'd1;
                        if (cnt == len - 8'd1) fld <= F_CK;
                     end
                     default: begin
                        if ((sum8 + byte_now) != 8'd0) st <= S_HALT;
                        else if (is_end)               st <= S_SUMH;
                        else                           st <= S_SEEK;
                     end
                  endcase
               end
            end
            S_SUMH: if (tx_ready) st <= S_SUML;
            S_SUML: if (tx_ready) st <= S_DONE;
            default: ;
         endcase
      end
   end

   always_comb begin
      tx_valid = 1'b1;
      tx_data  = 8'h00;
      case (st)
         S_ECHO: tx_data = CMD_LOAD;
         S_ERR:  tx_data = CMD_BAD;
         S_SUMH: tx_data = sum16[15:8];
         S_SUML: tx_data = sum16[7:0];
         default: tx_valid = 1'b0;
      endcase
      done   = (st == S_DONE);
      halted = (st == S_HALT);
   end

   p_tx_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
   p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   p_halt_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !tx_valid && !ram_we);
   p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && $stable(jump_addr));
   p_done_not_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && halted));
endmodule

// File: tb/hexram_loader_tb_top.sv
module hexram_loader_tb_top;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = 8'h00;
   logic          rx_err = 1'b0;
   logic          tx_valid;
   logic [7:0]    tx_data;
   logic          tx_ready;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;
   logic          done;
   logic [15:0]   jump_addr;
   logic          halted;

   int nchk = 0, nfail = 0;
   logic [7:0]    txq[$];
   logic [AW+7:0] wq[$];
   string         tx_tag = "R2";
   logic [15:0]   exp_sum;
   logic [15:0]   exp_jump;
   bit            seen_first;
   logic [2:0]    rdy_cnt = 3'd0;

   always #5 clk = ~clk;

   always @(posedge clk) rdy_cnt <= rdy_cnt + 3'd1;
   assign tx_ready = (rdy_cnt[1:0] != 2'b01);

   hexram_loader #(.AW(AW)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .rx_valid (rx_valid), .rx_data (rx_data), .rx_err (rx_err),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
      .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
      .done (done), .jump_addr (jump_addr), .halted (halted)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   logic       prev_stall = 1'b0;
   logic [7:0] prev_tx = 8'h00;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) chk(tx_valid && tx_data == prev_tx, "R14", {23'd0, tx_valid, tx_data}, {24'd1, prev_tx});
         if (tx_valid && tx_ready) begin
            if (txq.size() == 0) chk(1'b0, {tx_tag, " unexpected tx"}, {24'd0, tx_data}, 32'hFFFF_FFFF);
            else begin
               logic [7:0] e;
               e = txq.pop_front();
               chk(tx_data == e, tx_tag, {24'd0, tx_data}, {24'd0, e});
            end
         end
         if (ram_we) begin
            if (wq.size() == 0) chk(1'b0, "R6 R13 unexpected write", {ram_addr, ram_wdata}, 32'hFFFF_FFFF);
            else begin
               logic [AW+7:0] e;
               e = wq.pop_front();
               chk({ram_addr, ram_wdata} == e, "R6", {ram_addr, ram_wdata}, e);
            end
         end
         prev_stall = tx_valid && !tx_ready;
         prev_tx    = tx_data;
      end else prev_stall = 1'b0;
   end

   function automatic logic [7:0] hexch(input logic [3:0] n, input bit lc);
      if (n < 4'd10) return 8'h30 + {4'd0, n};
      return (lc ? 8'h57 : 8'h37) + {4'd0, n};
   endfunction

   task automatic send_ch(input logic [7:0] c, input bit err);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = c; rx_err = err;
      @(negedge clk);
      rx_valid = 1'b0; rx_err = 1'b0;
   endtask

   task automatic send_hex(input logic [7:0] b, input bit lc);
      send_ch(hexch(b[7:4], lc), 1'b0);
      send_ch(hexch(b[3:0], lc), 1'b0);
   endtask

   // driver: pushes expected writes, then sends the record
   task automatic send_rec(input logic [15:0] a, input logic [7:0] t, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           input bit lc, input bit bad_ck, input bit expect_wr);
      logic [7:0] s, ck, d;
      s = 8'(n) + a[15:8] + a[7:0] + t;
      for (int i = 0; i < n; i++) begin
         d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
         s = s + d;
         if (expect_wr) begin
            logic [15:0] wa;
            wa = a + 16'(i);
            wq.push_back({wa[AW-1:0], d});
            exp_sum = exp_sum + {8'd0, d};
         end
      end
      if (expect_wr && !seen_first) begin seen_first = 1'b1; exp_jump = a; end
      ck = 8'd0 - s;
      if (bad_ck) ck = ck ^ 8'h01;
      send_ch(8'h3A, 1'b0);
      send_hex(8'(n), lc);
      send_hex(a[15:8], lc);
      send_hex(a[7:0], lc);
      send_hex(t, lc);
      for (int i = 0; i < n; i++) send_hex((i == 0) ? d0 : (i == 1) ? d1 : d2, lc);
      send_hex(ck, lc);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      txq.delete(); wq.delete();
      exp_sum = 16'd0; exp_jump = 16'd0; seen_first = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain();
      wait (txq.size() == 0 && wq.size() == 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic start_ok();
      tx_tag = "R2";
      txq.push_back(8'h60);
      send_ch(8'h60, 1'b0);
      drain();
   endtask

   task automatic expect_halt(input string tag);
      repeat (6) @(negedge clk);
      chk(halted == 1'b1, tag, {31'd0, halted}, 32'd1);
      chk(tx_valid == 1'b0, tag, {31'd0, tx_valid}, 32'd0);
      tx_tag = "R13";
      send_rec(16'h0010, 8'h00, 1, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      repeat (6) @(negedge clk);
      chk(halted == 1'b1 && wq.size() == 0 && txq.size() == 0, "R13", {31'd0, halted}, 32'd1);
   endtask

   task automatic finish_end(input string tag);
      tx_tag = "R11";
      txq.push_back(exp_sum[15:8]);
      txq.push_back(exp_sum[7:0]);
      send_rec(16'h0000, 8'h01, 0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      drain();
      chk(done == 1'b1 && halted == 1'b0, tag, {30'd0, done, halted}, 32'd2);
      chk(jump_addr == exp_jump, "R12", {16'd0, jump_addr}, {16'd0, exp_jump});
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "R1 watchdog", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      @(negedge clk);
      chk(!tx_valid && !ram_we && !done && !halted, "R1",
          {28'd0, tx_valid, ram_we, done, halted}, 32'd0);

      // clean load: garbage before marks (R4), upper/lower case (R5), wrap (R6)
      start_ok();
      send_ch(8'h31, 1'b0); send_ch(8'h41, 1'b0); send_ch(8'h0A, 1'b0); send_ch(8'h21, 1'b0);
      repeat (3) @(negedge clk);
      chk(!halted && wq.size() == 0, "R4", {31'd0, halted}, 32'd0);
      send_rec(16'h0100, 8'h00, 3, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b1);
      send_ch(8'h46, 1'b0); send_ch(8'h30, 1'b0);
      send_rec(16'h1FFE, 8'h00, 3, 8'hAB, 8'hCD, 8'hEF, 1'b1, 1'b0, 1'b1);
      send_rec(16'h0200, 8'h00, 2, 8'hFF, 8'hFE, 8'h00, 1'b1, 1'b0, 1'b1);
      drain();
      chk(wq.size() == 0 && !halted, "R5", {31'd0, halted}, 32'd0);
      finish_end("R11");
      tx_tag = "R12";
      send_rec(16'h0300, 8'h00, 1, 8'h77, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      chk(done == 1'b1 && jump_addr == 16'h0100, "R12", {16'd0, jump_addr}, 32'h0100);

      // end record only: empty sum, jump 0
      do_reset();
      start_ok();
      finish_end("R12");

      // wrong command
      do_reset();
      tx_tag = "R3";
      repeat (3) txq.push_back(8'h63);
      send_ch(8'h41, 1'b0);
      drain();
      expect_halt("R3");

      // non-hex character inside record
      do_reset();
      start_ok();
      send_ch(8'h3A, 1'b0); send_ch(8'h30, 1'b0); send_ch(8'h47, 1'b0);
      expect_halt("R7");

      // bad record checksum (bytes already written stay)
      do_reset();
      start_ok();
      send_rec(16'h0040, 8'h00, 1, 8'h99, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      expect_halt("R8");

      // unknown type, then end record with data
      do_reset();
      start_ok();
      send_rec(16'h0000, 8'h02, 0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      expect_halt("R9");
      do_reset();
      start_ok();
      send_rec(16'h0000, 8'h01, 1, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      expect_halt("R9");

      // receiver error while scanning, and inside a record
      do_reset();
      start_ok();
      send_ch(8'h3A, 1'b1);
      expect_halt("R10");
      do_reset();
      start_ok();
      send_ch(8'h3A, 1'b0); send_ch(8'h30, 1'b0); send_ch(8'h31, 1'b1);
      expect_halt("R10");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule